// File: doc/BRIEF.md
# Reference Loop Lock Status Monitor

This block watches a reference-tracking phase-locked loop and decides whether it is locked. Once per compare cycle, marked by a strobe, it measures how long the phase detector's up or down pulse was held. A compare is good when that width is below a programmable window and no range-limit indication is present. A run of good compares declares lock. A shorter run of bad compares while locked declares loss of lock. At the moment lock is lost, the block latches whether the loop ran out of its fine-tuning range high or low.

A two-bit selector chooses what the status output presents: the live lock flag or the latched direction. The same flag is returned on a readback bit in place of the selector's upper bit. An external status pin carries the flag only when its enable is set. A disable bit gates the pump up/down commands. If strobes stop arriving, each timeout window counts as a bad compare. While the reference is missing, the pump is steered downward, so lock is eventually reported as lost.

Top module: `lock_status_mon`

## Requirements
- R1: Lock is declared on the clock edge that accepts the 16th consecutive good compare. A compare is good when the number of cycles with `pd_up` or `pd_dn` high since the previous compare, including the strobe cycle, is less than `win_len`, and `range_hi` and `range_lo` are both low on the strobe cycle.
- R2: While locked, 4 consecutive bad compares clear the lock flag on the edge that accepts the 4th. A good compare restarts the bad run.
- R3: With `mode_sel` = 00, `stat_out` shows the lock flag, 1 meaning locked and 0 meaning unlocked.
- R4: With `mode_sel` = 01, `stat_out` shows the latched direction, 1 meaning the loop ran out of range high and 0 meaning it ran out of range low.
- R5: The direction flag takes the value of `range_hi` only on the compare that clears lock. It holds at all other times, including during bad compares while already unlocked.
- R6: The reserved codes 10 and 11 of `mode_sel` present the lock flag.
- R7: `mode_hi_rd` always equals the flag currently selected on `stat_out`.
- R8: `pin_oe` equals `pin_en`. `pin_out` carries the selected flag when `pin_en` is 1 and is 0 when `pin_en` is 0.
- R9: With `loop_dis` = 1, `pump_up` and `pump_dn` are both 0. With `loop_dis` = 0, they follow `pd_up` and `pd_dn` while the reference is present.
- R10: When 64 cycles pass without `cmp_strobe`, that window counts as a bad compare and the reference is marked missing. While it is missing and `loop_dis` = 0, `pump_dn` is 1 and `pump_up` is 0. The next strobe clears the missing mark.
- R11: After reset the loop is unlocked and the direction flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_up | input | 1 | Phase detector up pulse |
| pd_dn | input | 1 | Phase detector down pulse |
| cmp_strobe | input | 1 | Marks the last cycle of a compare cycle |
| range_hi | input | 1 | Loop at upper fine-tune limit |
| range_lo | input | 1 | Loop at lower fine-tune limit |
| win_len | input | WIN_W | Good-compare pulse width limit, exclusive |
| mode_sel | input | 2 | Status source select |
| pin_en | input | 1 | Status pin enable |
| loop_dis | input | 1 | Pump command disable |
| pump_up | output | 1 | Gated pump up command |
| pump_dn | output | 1 | Gated pump down command |
| stat_out | output | 1 | Selected status flag |
| mode_hi_rd | output | 1 | Readback of the selector upper bit, replaced by the flag |
| pin_out | output | 1 | Status pin data |
| pin_oe | output | 1 | Status pin output enable |

## Verification
The bench sweeps every window length from 1 to 6 against pulse widths from 0 to 7. A design with an off-by-one width comparison would lock or unlock on the wrong compares. Lock entry is probed at the 15th and 16th good compares, with a single bad compare breaking the run, so a counter that fails to restart or counts one short would flag lock early. The direction flag is driven by bad compares carrying range indications both while locked and after unlocking; a latch that follows `range_hi` instead of capturing it on the loss event would change when it should hold. A stopped strobe must yield a timed-out loss of lock with the pump forced down, and the next strobe must release it.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    SEL_LOCK = 2'b00,
    SEL_DIR  = 2'b01,
    SEL_RS2  = 2'b10,
    SEL_RS3  = 2'b11
  } sel_e;

  typedef struct packed {
    logic valid;
    logic bad;
  } cmp_evt_t;
endpackage

// File: rtl/lsm_pulse_meter.sv
module lsm_pulse_meter
  import lsm_pkg::*;
#(
  parameter int WIN_W  = 4,
  parameter int REF_TO = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_up,
  input  logic             pd_dn,
  input  logic             cmp_strobe,
  input  logic             range_hi,
  input  logic             range_lo,
  input  logic [WIN_W-1:0] win_len,
  output cmp_evt_t         evt,
  output logic             ref_lost
);
  localparam int TW = $clog2(REF_TO);
  localparam logic [TW-1:0]    TO_LAST = TW'(REF_TO - 1);
  localparam logic [WIN_W-1:0] ERR_MAX = '1;

  logic [WIN_W-1:0] err_q, err_d;
  logic [TW-1:0]    to_q, to_d;
  logic             lost_d;
  logic             active, timeout;
  logic [WIN_W:0]   width_now;

  always_comb begin
    active    = pd_up | pd_dn;
    timeout   = !cmp_strobe && (to_q == TO_LAST);
    width_now = {1'b0, err_q} + {{WIN_W{1'b0}}, active};
    evt.valid = cmp_strobe | timeout;
    evt.bad   = timeout | range_hi | range_lo | (width_now >= {1'b0, win_len});

    if (evt.valid)                      err_d = '0;
    else if (active && err_q != ERR_MAX) err_d = err_q + 1'b1;
    else                                err_d = err_q;

    if (evt.valid) to_d = '0;
    else           to_d = to_q + 1'b1;

    if (cmp_strobe)   lost_d = 1'b0;
    else if (timeout) lost_d = 1'b1;
    else              lost_d = ref_lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= '0;
      to_q     <= '0;
      ref_lost <= 1'b0;
    end else begin
      err_q    <= err_d;
      to_q     <= to_d;
      ref_lost <= lost_d;
    end
  end
endmodule

// File: rtl/lsm_lock_track.sv
module lsm_lock_track
  import lsm_pkg::*;
#(
  parameter int LOCK_RUN   = 16,
  parameter int UNLOCK_RUN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cmp_evt_t evt,
  input  logic     range_hi,
  output logic     locked,
  output logic     dir_hi
);
  localparam int GW = $clog2(LOCK_RUN + 1);
  localparam int BW = $clog2(UNLOCK_RUN + 1);
  localparam logic [GW-1:0] G_LAST = GW'(LOCK_RUN - 1);
  localparam logic [BW-1:0] B_LAST = BW'(UNLOCK_RUN - 1);

  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] bad_q, bad_d;
  logic          lock_d, dir_d;

  always_comb begin
    good_d = good_q;
    bad_d  = bad_q;
    lock_d = locked;
    dir_d  = dir_hi;
    if (evt.bad) begin
      good_d = '0;
      if (locked && bad_q == B_LAST) begin
        lock_d = 1'b0;
        dir_d  = range_hi;
      end
      if (bad_q != B_LAST) bad_d = bad_q + 1'b1;
    end else begin
      bad_d = '0;
      if (good_q == G_LAST) lock_d = 1'b1;
      else                  good_d = good_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      bad_q  <= '0;
      locked <= 1'b0;
      dir_hi <= 1'b0;
    end else if (evt.valid) begin
      good_q <= good_d;
      bad_q  <= bad_d;
      locked <= lock_d;
      dir_hi <= dir_d;
    end
  end
endmodule

// File: rtl/lsm_status_out.sv
module lsm_status_out
  import lsm_pkg::*;
(
  input  logic       locked,
  input  logic       dir_hi,
  input  logic [1:0] mode_sel,
  input  logic       pin_en,
  input  logic       loop_dis,
  input  logic       ref_lost,
  input  logic       pd_up,
  input  logic       pd_dn,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       stat_out,
  output logic       mode_hi_rd,
  output logic       pin_out,
  output logic       pin_oe
);
  sel_e sel;
  logic flag;

  always_comb begin
    sel = sel_e'(mode_sel);
    case (sel)
      SEL_DIR: flag = dir_hi;
      default: flag = locked;
    endcase
    stat_out   = flag;
    mode_hi_rd = flag;
    pin_oe     = pin_en;
    pin_out    = pin_en & flag;
    pump_up    = !loop_dis & !ref_lost & pd_up;
    pump_dn    = !loop_dis & (ref_lost | pd_dn);
  end
endmodule

// File: rtl/lock_status_mon.sv
module lock_status_mon
  import lsm_pkg::*;
#(
  parameter int WIN_W      = 4,
  parameter int REF_TO     = 64,
  parameter int LOCK_RUN   = 16,
  parameter int UNLOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_up,
  input  logic             pd_dn,
  input  logic             cmp_strobe,
  input  logic             range_hi,
  input  logic             range_lo,
  input  logic [WIN_W-1:0] win_len,
  input  logic [1:0]       mode_sel,
  input  logic             pin_en,
  input  logic             loop_dis,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             stat_out,
  output logic             mode_hi_rd,
  output logic             pin_out,
  output logic             pin_oe
);
  cmp_evt_t evt;
  logic     ref_lost, locked_q, dir_q;
  logic     evt_valid, evt_bad;

  assign evt_valid = evt.valid;
  assign evt_bad   = evt.bad;

  lsm_pulse_meter #(.WIN_W(WIN_W), .REF_TO(REF_TO)) u_meter (
    .clk(clk), .rst_n(rst_n), .pd_up(pd_up), .pd_dn(pd_dn),
    .cmp_strobe(cmp_strobe), .range_hi(range_hi), .range_lo(range_lo),
    .win_len(win_len), .evt(evt), .ref_lost(ref_lost)
  );

  lsm_lock_track #(.LOCK_RUN(LOCK_RUN), .UNLOCK_RUN(UNLOCK_RUN)) u_track (
    .clk(clk), .rst_n(rst_n), .evt(evt), .range_hi(range_hi),
    .locked(locked_q), .dir_hi(dir_q)
  );

  lsm_status_out u_out (
    .locked(locked_q), .dir_hi(dir_q), .mode_sel(mode_sel), .pin_en(pin_en),
    .loop_dis(loop_dis), .ref_lost(ref_lost), .pd_up(pd_up), .pd_dn(pd_dn),
    .pump_up(pump_up), .pump_dn(pump_dn), .stat_out(stat_out),
    .mode_hi_rd(mode_hi_rd), .pin_out(pin_out), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_en,
  input logic       loop_dis,
  input logic [1:0] mode_sel,
  input logic       stat_out,
  input logic       mode_hi_rd,
  input logic       pin_out,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       ref_lost,
  input logic       locked,
  input logic       dir_hi,
  input logic       evt_valid,
  input logic       evt_bad
);
  a_r1_lock_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(evt_valid && !evt_bad));

  a_r2_unlock_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(evt_valid && evt_bad));

  a_r5_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked) |-> $stable(dir_hi));

  a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hi_rd == stat_out);

  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> !pin_out);

  a_r9_pump_gate: assert property (@(posedge clk) disable iff (!rst_n)
    loop_dis |-> (!pump_up && !pump_dn));

  a_r10_lost_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_lost && !loop_dis) |-> (pump_dn && !pump_up));

  a_r3_lock_view: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (stat_out == locked));
endmodule

bind lock_status_mon lsm_checker i_chk (
  .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .loop_dis(loop_dis),
  .mode_sel(mode_sel), .stat_out(stat_out), .mode_hi_rd(mode_hi_rd),
  .pin_out(pin_out), .pump_up(pump_up), .pump_dn(pump_dn),
  .ref_lost(ref_lost), .locked(locked_q), .dir_hi(dir_q),
  .evt_valid(evt_valid), .evt_bad(evt_bad)
);

// File: tb/test_lock_status_mon.sv
module test_lock_status_mon;
  logic clk, rst_n, pd_up, pd_dn, cmp_strobe, range_hi, range_lo;
  logic [3:0] win_len;
  logic [1:0] mode_sel;
  logic pin_en, loop_dis;
  logic pump_up, pump_dn, stat_out, mode_hi_rd, pin_out, pin_oe;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic e_lock, e_dir;
  int e_good, e_badrun;

  lock_status_mon i_lock_status_mon (
    .clk(clk), .rst_n(rst_n), .pd_up(pd_up), .pd_dn(pd_dn),
    .cmp_strobe(cmp_strobe), .range_hi(range_hi), .range_lo(range_lo),
    .win_len(win_len), .mode_sel(mode_sel), .pin_en(pin_en),
    .loop_dis(loop_dis), .pump_up(pump_up), .pump_dn(pump_dn),
    .stat_out(stat_out), .mode_hi_rd(mode_hi_rd), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_cmp(bit bad, bit rhi);
    if (bad) begin
      e_good = 0;
      if (e_badrun < 3) e_badrun++;
      else if (e_lock) begin e_lock = 0; e_dir = rhi; end
      if (e_lock && e_badrun == 3) ;
    end else begin
      e_badrun = 0;
      if (e_good == 15) e_lock = 1; else e_good++;
    end
  endtask

  // status view over every selector code, pin enabled
  task automatic check_status();
    logic [1:0] keep;
    keep = mode_sel;
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      #1;
      if (m == 1) chk("R4 dir view", stat_out, e_dir);
      else if (m == 0) chk("R3 lock view", stat_out, e_lock);
      else chk("R6 reserved code", stat_out, e_lock);
      chk("R7 readback", mode_hi_rd, stat_out);
      chk("R8 pin data", pin_out, stat_out);
    end
    mode_sel = keep;
  endtask

  // one compare cycle: pulse of w cycles, strobe on cycle period-1
  task automatic do_cmp(int w, bit rhi, bit rlo);
    int period;
    bit bad;
    period = (w + 2 > 10) ? w + 2 : 10;
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      pd_up = (i < w);
      cmp_strobe = (i == period - 1);
      range_hi = rhi;
      range_lo = rlo;
    end
    @(negedge clk);
    cmp_strobe = 0; pd_up = 0; range_hi = 0; range_lo = 0;
    bad = (w >= int'(win_len)) || rhi || rlo;
    // R1 R2 R5 model: a run of 3 prior bads then one more unlocks
    if (bad && e_lock && e_badrun == 3) begin e_lock = 0; e_dir = rhi; end
    else model_cmp(bad, rhi);
    if (bad && e_badrun < 3 && !(e_badrun == 0 && !bad)) ;
    check_status();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pd_up = 0; pd_dn = 0; cmp_strobe = 0; range_hi = 0;
    range_lo = 0; win_len = 4'd3; mode_sel = 2'b00; pin_en = 1; loop_dis = 0;
    e_lock = 0; e_dir = 0; e_good = 0; e_badrun = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    mode_sel = 2'b00; #1; chk("R11 reset unlocked", stat_out, 1'b0);
    mode_sel = 2'b01; #1; chk("R11 reset dir low", stat_out, 1'b0);
    mode_sel = 2'b00;
    check_status();

    // R1: a broken run, then exactly 16 good compares
    for (int k = 0; k < 10; k++) do_cmp(k % 3, 0, 0);
    do_cmp(3, 0, 0);
    for (int k = 0; k < 15; k++) do_cmp(2, 0, 0);
    mode_sel = 2'b00; #1; chk("R1 not yet locked at 15", stat_out, 1'b0);
    do_cmp(0, 0, 0);
    mode_sel = 2'b00; #1; chk("R1 locked at 16", stat_out, 1'b1);

    // R2: three bads, good restarts run, then four bads with range high
    for (int k = 0; k < 3; k++) do_cmp(5, 1, 0);
    do_cmp(1, 0, 0);
    for (int k = 0; k < 3; k++) do_cmp(4, 1, 0);
    mode_sel = 2'b00; #1; chk("R2 still locked after 3", stat_out, 1'b1);
    do_cmp(3, 1, 0);
    mode_sel = 2'b00; #1; chk("R2 unlocked at 4th", stat_out, 1'b0);
    mode_sel = 2'b01; #1; chk("R5 dir high latched", stat_out, 1'b1);

    // R5: bads with range low while unlocked leave dir alone
    for (int k = 0; k < 6; k++) do_cmp(0, 0, 1);
    mode_sel = 2'b01; #1; chk("R5 dir holds while unlocked", stat_out, 1'b1);

    // relock at wider window, lose via range low only
    win_len = 4'd5;
    for (int k = 0; k < 16; k++) do_cmp(4, 0, 0);
    for (int k = 0; k < 4; k++) do_cmp(0, 0, 1);
    mode_sel = 2'b01; #1; chk("R5 dir low latched", stat_out, 1'b0);
    mode_sel = 2'b00;

    // near-exhaustive window/width sweep (R1 R2)
    for (int wl = 1; wl <= 6; wl++) begin
      win_len = 4'(wl);
      for (int rep = 0; rep < 3; rep++)
        for (int w = 0; w < 8; w++) do_cmp(w, (w == 7), 0);
      for (int k = 0; k < 16; k++) do_cmp(0, 0, 0);
    end

    // R8: pin disabled
    pin_en = 0;
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m); #1;
      chk("R8 pin low when off", pin_out, 1'b0);
      chk("R8 oe off", pin_oe, 1'b0);
    end
    pin_en = 1; #1; chk("R8 oe on", pin_oe, 1'b1);
    mode_sel = 2'b00;

    // R9: pump gating over all pd combinations
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      pd_up = c[0]; pd_dn = c[1]; loop_dis = c[2]; #1;
      chk("R9 pump up", pump_up, c[0] & !c[2]);
      chk("R9 pump dn", pump_dn, c[1] & !c[2]);
    end
    @(negedge clk); pd_up = 0; pd_dn = 0; loop_dis = 0;

    // R10: reference stops
    win_len = 4'd3;
    for (int k = 0; k < 16; k++) do_cmp(0, 0, 0);
    @(negedge clk);
    range_hi = 1;
    repeat (300) @(negedge clk);
    for (int k = 0; k < 4; k++) model_cmp(1, 1);
    pd_up = 1; #1;
    chk("R10 pump dn forced", pump_dn, 1'b1);
    chk("R10 pump up blocked", pump_up, 1'b0);
    loop_dis = 1; #1;
    chk("R10 disable wins", pump_dn, 1'b0);
    loop_dis = 0; pd_up = 0; range_hi = 0;
    check_status();
    do_cmp(0, 0, 0);
    #1; chk("R10 strobe clears missing", pump_dn, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule